// File: doc/BRIEF.md
# Doorbell and message interrupt unit

This block is a register bank that sits between a local processor and a remote bus master. Each side posts 32-bit words to the other through two message slots per direction, and raises events through a doorbell register per direction. The doorbell collects set bits until the receiver writes them back. A write from one side raises a status bit that only the other side sees. Each side has its own status and mask registers and one level-sensitive interrupt line.

Both sides use the same simple access port: a request with a write flag, a 5-bit address and write data. Every request gets a registered response one cycle later, with read data and an error flag. Queue state (post queue not empty, queue overflows) and a machine-check level come in as plain inputs. They appear as status bits only. The queues themselves are kept outside the block.

Top module: `xside_mailbox`

## Requirements
- R1: Address bits [4:2] pick the register kind and bits [1:0] pick the index. Kinds are: 0 send message, 1 receive message, 2 send doorbell, 3 receive doorbell, 4 own status, 5 own mask. Kinds 6 and 7 read as zero and ignore writes. A message access with index 2 or 3 is rejected: the response carries err=1 and read data 0, and no register changes.
- R2: A remote send-message write sets inbound status bit `index`. A local send-message write sets outbound status bit `index`. The other side reads the word through its receive-message kind.
- R3: Reading a message register, through either kind, returns the last value written to it. The read changes no data and no status.
- R4: Inbound status (local side): bit 0 message 0, bit 1 message 1, bit 3 doorbell nonzero, bit 4 machine check, bit 5 inbound post queue not empty, bit 7 post-queue overflow, bit 8 free-queue overflow. Outbound status (remote side): bits 0, 1, 3 as above, and bit 5 outbound post queue not empty. All other bits read zero.
- R5: Mask bits sit at the same positions as the status bits, and a 1 disables that source. After reset every valid mask bit is 1: inbound 0x1BB, outbound 0x2B. Writes to reserved mask bits are dropped, so those bits read zero.
- R6: Each side's interrupt output is high exactly when its status has a set bit whose mask bit is 0.
- R7: A send-doorbell write ORs the written ones into the other side's doorbell. Existing bits are kept.
- R8: A receive-doorbell write clears the bits written as 1. The doorbell status bit stays set while any doorbell bit is still 1.
- R9: A local send-doorbell write affects only bits 28:0 of the outbound doorbell. Bits 31:29 stay zero.
- R10: Writing 1 to a message bit of the own status register clears it. The doorbell and queue status bits do not change on a status write. If a message write and a clear of the same bit fall in the same cycle, the bit ends up set.
- R11: Each request gets an ack exactly one cycle later. A read returns the register value as it was before that cycle's edge. A write returns read data 0 and err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req | input | 1 | Local access request |
| loc_wr | input | 1 | Local access is a write |
| loc_addr | input | 5 | Local register kind [4:2] and index [1:0] |
| loc_wdata | input | 32 | Local write data |
| loc_ack | output | 1 | Local response valid |
| loc_err | output | 1 | Local access rejected |
| loc_rdata | output | 32 | Local read data |
| loc_irq | output | 1 | Local interrupt level |
| rem_req | input | 1 | Remote access request |
| rem_wr | input | 1 | Remote access is a write |
| rem_addr | input | 5 | Remote register kind [4:2] and index [1:0] |
| rem_wdata | input | 32 | Remote write data |
| rem_ack | output | 1 | Remote response valid |
| rem_err | output | 1 | Remote access rejected |
| rem_rdata | output | 32 | Remote read data |
| rem_irq | output | 1 | Remote interrupt level |
| mcheck_in | input | 1 | Machine-check level, inbound status |
| in_post_nempty | input | 1 | Inbound post queue not empty |
| out_post_nempty | input | 1 | Outbound post queue not empty |
| in_post_ovf | input | 1 | Inbound post queue overflow |
| out_free_ovf | input | 1 | Outbound free queue overflow |

## Verification
The message slots are tested with a distinct word in each slot, read back twice. This shows whether a read has side effects or mixes up the slots. An out-of-range index that aliases slot 1 in its low bit catches a decoder that drops the upper index bit. The doorbells are tested in three ways:
- two disjoint patterns are written, which separates OR-accumulation from overwrite;
- they are cleared partially and then fully, which shows whether the status bit follows the last remaining one;
- the local side writes all ones, which exposes the three bits it may not write.

A clear of a message bit is also issued in the same cycle as a new message to that slot. This shows the set-over-clear priority.

// File: rtl/xm_pkg.sv
package xm_pkg;
  localparam int DW     = 32;
  localparam int NMSG   = 2;
  localparam int MSEL_W = (NMSG > 1) ? $clog2(NMSG) : 1;
  localparam int IDX_W  = 2;
  localparam int KIND_W = 3;
  localparam int ADDR_W = KIND_W + IDX_W;

  // status / mask bit positions (message bits occupy [NMSG-1:0])
  localparam int B_DB   = 3;
  localparam int B_MC   = 4;
  localparam int B_PQ   = 5;
  localparam int B_POVF = 7;
  localparam int B_FOVF = 8;

  typedef enum logic [KIND_W-1:0] {
    K_MSG_TX = 3'd0,
    K_MSG_RX = 3'd1,
    K_DB_TX  = 3'd2,
    K_DB_RX  = 3'd3,
    K_STAT   = 3'd4,
    K_MASK   = 3'd5
  } kind_e;

  function automatic logic [DW-1:0] stat_pack(input logic [NMSG-1:0] msg,
                                              input logic db, input logic pq,
                                              input logic mc, input logic povf,
                                              input logic fovf, input logic inbound);
    logic [DW-1:0] s;
    s           = '0;
    s[NMSG-1:0] = msg;
    s[B_DB]     = db;
    s[B_PQ]     = pq;
    s[B_MC]     = mc & inbound;
    s[B_POVF]   = povf & inbound;
    s[B_FOVF]   = fovf & inbound;
    return s;
  endfunction

  localparam logic [DW-1:0] IN_VALID  = stat_pack('1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
  localparam logic [DW-1:0] OUT_VALID = stat_pack('1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

  function automatic logic is_msg_kind(input logic [KIND_W-1:0] k);
    return (k == K_MSG_TX) || (k == K_MSG_RX);
  endfunction

  function automatic logic idx_ok(input logic [IDX_W-1:0] idx);
    return 32'(idx) < NMSG;
  endfunction

  function automatic logic [DW-1:0] db_next(input logic [DW-1:0] cur,
                                            input logic set_en, input logic [DW-1:0] set_v,
                                            input logic [DW-1:0] wmask,
                                            input logic clr_en, input logic [DW-1:0] clr_v);
    logic [DW-1:0] c, s;
    c = clr_en ? clr_v : '0;
    s = set_en ? (set_v & wmask) : '0;
    return (cur & ~c) | s;
  endfunction

  function automatic logic irq_of(input logic [DW-1:0] stat, input logic [DW-1:0] mask);
    return |(stat & ~mask);
  endfunction
endpackage

// File: rtl/xm_port.sv
module xm_port
  import xm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NMSG-1:0][DW-1:0]    tx_msg,
  input  logic [NMSG-1:0][DW-1:0]    rx_msg,
  input  logic [DW-1:0]              tx_db,
  input  logic [DW-1:0]              rx_db,
  input  logic [DW-1:0]              stat,
  input  logic [DW-1:0]              mask,
  output logic                       msg_we,
  output logic [IDX_W-1:0]           msg_idx,
  output logic                       db_set,
  output logic                       db_clr,
  output logic                       stat_we,
  output logic                       mask_we,
  output logic                       ack,
  output logic                       err,
  output logic [DW-1:0]              rdata
);
  kind_e              kind;
  logic [IDX_W-1:0]   idx;
  logic [MSEL_W-1:0]  sel;
  logic               bad;
  logic               wr_ok;
  logic [DW-1:0]      rd_val;

  assign kind    = kind_e'(addr[ADDR_W-1:IDX_W]);
  assign idx     = addr[IDX_W-1:0];
  assign sel     = idx[MSEL_W-1:0];
  assign bad     = is_msg_kind(kind) && !idx_ok(idx);
  assign wr_ok   = req && wr && !bad;

  assign msg_we  = wr_ok && (kind == K_MSG_TX);
  assign msg_idx = idx;
  assign db_set  = wr_ok && (kind == K_DB_TX);
  assign db_clr  = wr_ok && (kind == K_DB_RX);
  assign stat_we = wr_ok && (kind == K_STAT);
  assign mask_we = wr_ok && (kind == K_MASK);

  always_comb begin
    case (kind)
      K_MSG_TX: rd_val = tx_msg[sel];
      K_MSG_RX: rd_val = rx_msg[sel];
      K_DB_TX:  rd_val = tx_db;
      K_DB_RX:  rd_val = rx_db;
      K_STAT:   rd_val = stat;
      K_MASK:   rd_val = mask;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      err   <= req && bad;
      rdata <= (req && !wr && !bad) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/xm_msg_bank.sv
module xm_msg_bank
  import xm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DW-1:0]           wdata,
  input  logic [NMSG-1:0]         clr,
  output logic [NMSG-1:0][DW-1:0] msg,
  output logic [NMSG-1:0]         flag
);
  for (genvar g = 0; g < NMSG; g++) begin : g_slot
    logic          hit;
    logic [DW-1:0] word_q;
    logic          flag_q;

    assign hit = we && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        flag_q <= 1'b0;
      end else begin
        if (hit) word_q <= wdata;
        // a new message outranks a clear in the same cycle
        if (hit)         flag_q <= 1'b1;
        else if (clr[g]) flag_q <= 1'b0;
      end
    end

    assign msg[g]  = word_q;
    assign flag[g] = flag_q;
  end
endmodule

// File: rtl/xm_doorbell.sv
module xm_doorbell
  import xm_pkg::*;
#(
  parameter logic [DW-1:0] WMASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [DW-1:0] set_v,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_v,
  output logic [DW-1:0] bits,
  output logic          any
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= db_next(bits, set_en, set_v, WMASK, clr_en, clr_v);
  end

  assign any = |bits;
endmodule

// File: rtl/xside_mailbox.sv
module xside_mailbox
  import xm_pkg::*;
#(
  parameter logic [DW-1:0] LOC_DB_WMASK = 32'h1FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_req,
  input  logic              loc_wr,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DW-1:0]     loc_wdata,
  output logic              loc_ack,
  output logic              loc_err,
  output logic [DW-1:0]     loc_rdata,
  output logic              loc_irq,
  input  logic              rem_req,
  input  logic              rem_wr,
  input  logic [ADDR_W-1:0] rem_addr,
  input  logic [DW-1:0]     rem_wdata,
  output logic              rem_ack,
  output logic              rem_err,
  output logic [DW-1:0]     rem_rdata,
  output logic              rem_irq,
  input  logic              mcheck_in,
  input  logic              in_post_nempty,
  input  logic              out_post_nempty,
  input  logic              in_post_ovf,
  input  logic              out_free_ovf
);
  // local side strobes
  logic             l_msg_we, l_db_set, l_db_clr, l_stat_we, l_mask_we;
  logic [IDX_W-1:0] l_msg_idx;
  // remote side strobes
  logic             r_msg_we, r_db_set, r_db_clr, r_stat_we, r_mask_we;
  logic [IDX_W-1:0] r_msg_idx;

  // named state brought out for the checker
  logic [NMSG-1:0][DW-1:0] in_msg, out_msg;
  logic [NMSG-1:0]         in_flag, out_flag;
  logic [DW-1:0]           in_db, out_db;
  logic                    in_db_any, out_db_any;
  logic [DW-1:0]           in_stat, out_stat;
  logic [DW-1:0]           in_mask, out_mask;

  // remote posts inbound messages; local write-one clears their flags
  xm_msg_bank u_in_bank (
    .clk, .rst_n,
    .we    (r_msg_we),
    .idx   (r_msg_idx),
    .wdata (rem_wdata),
    .clr   (l_stat_we ? loc_wdata[NMSG-1:0] : '0),
    .msg   (in_msg),
    .flag  (in_flag)
  );

  xm_msg_bank u_out_bank (
    .clk, .rst_n,
    .we    (l_msg_we),
    .idx   (l_msg_idx),
    .wdata (loc_wdata),
    .clr   (r_stat_we ? rem_wdata[NMSG-1:0] : '0),
    .msg   (out_msg),
    .flag  (out_flag)
  );

  xm_doorbell #(.WMASK('1)) u_in_db (
    .clk, .rst_n,
    .set_en (r_db_set), .set_v (rem_wdata),
    .clr_en (l_db_clr), .clr_v (loc_wdata),
    .bits   (in_db),    .any   (in_db_any)
  );

  xm_doorbell #(.WMASK(LOC_DB_WMASK)) u_out_db (
    .clk, .rst_n,
    .set_en (l_db_set), .set_v (loc_wdata),
    .clr_en (r_db_clr), .clr_v (rem_wdata),
    .bits   (out_db),   .any   (out_db_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mask  <= IN_VALID;
      out_mask <= OUT_VALID;
    end else begin
      if (l_mask_we) in_mask  <= loc_wdata & IN_VALID;
      if (r_mask_we) out_mask <= rem_wdata & OUT_VALID;
    end
  end

  assign in_stat  = stat_pack(in_flag, in_db_any, in_post_nempty, mcheck_in,
                              in_post_ovf, out_free_ovf, 1'b1);
  assign out_stat = stat_pack(out_flag, out_db_any, out_post_nempty, 1'b0,
                              1'b0, 1'b0, 1'b0);

  assign loc_irq = irq_of(in_stat, in_mask);
  assign rem_irq = irq_of(out_stat, out_mask);

  xm_port u_loc_port (
    .clk, .rst_n,
    .req     (loc_req),   .wr      (loc_wr),    .addr   (loc_addr),
    .tx_msg  (out_msg),   .rx_msg  (in_msg),
    .tx_db   (out_db),    .rx_db   (in_db),
    .stat    (in_stat),   .mask    (in_mask),
    .msg_we  (l_msg_we),  .msg_idx (l_msg_idx),
    .db_set  (l_db_set),  .db_clr  (l_db_clr),
    .stat_we (l_stat_we), .mask_we (l_mask_we),
    .ack     (loc_ack),   .err     (loc_err),   .rdata  (loc_rdata)
  );

  xm_port u_rem_port (
    .clk, .rst_n,
    .req     (rem_req),   .wr      (rem_wr),    .addr   (rem_addr),
    .tx_msg  (in_msg),    .rx_msg  (out_msg),
    .tx_db   (in_db),     .rx_db   (out_db),
    .stat    (out_stat),  .mask    (out_mask),
    .msg_we  (r_msg_we),  .msg_idx (r_msg_idx),
    .db_set  (r_db_set),  .db_clr  (r_db_clr),
    .stat_we (r_stat_we), .mask_we (r_mask_we),
    .ack     (rem_ack),   .err     (rem_err),   .rdata  (rem_rdata)
  );
endmodule

// File: rtl/xside_mailbox_chk.sv
module xside_mailbox_chk
  import xm_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    loc_req,
  input logic                    loc_wr,
  input logic [ADDR_W-1:0]       loc_addr,
  input logic                    loc_ack,
  input logic                    loc_err,
  input logic [DW-1:0]           loc_rdata,
  input logic                    loc_irq,
  input logic                    rem_req,
  input logic                    rem_wr,
  input logic [ADDR_W-1:0]       rem_addr,
  input logic                    rem_ack,
  input logic                    rem_irq,
  input logic [NMSG-1:0][DW-1:0] in_msg,
  input logic [NMSG-1:0]         in_flag,
  input logic [DW-1:0]           in_db,
  input logic [DW-1:0]           out_db,
  input logic [DW-1:0]           in_stat,
  input logic [DW-1:0]           out_stat,
  input logic [DW-1:0]           in_mask,
  input logic [DW-1:0]           out_mask
);
  logic [KIND_W-1:0] l_kind, r_kind;
  logic              l_bad, r_bad;

  assign l_kind = loc_addr[ADDR_W-1:IDX_W];
  assign r_kind = rem_addr[ADDR_W-1:IDX_W];
  assign l_bad  = is_msg_kind(l_kind) && (32'(loc_addr[IDX_W-1:0]) >= NMSG);
  assign r_bad  = is_msg_kind(r_kind) && (32'(rem_addr[IDX_W-1:0]) >= NMSG);

  // R1: rejected index gives err and zero data
  a_r1_loc_reject: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req && l_bad |=> loc_err && (loc_rdata == '0));

  // R1: rejected remote message write leaves inbound words alone
  a_r1_rem_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req && rem_wr && r_bad |=> $stable(in_msg));

  // R2: remote message post raises the inbound flag of that slot
  a_r2_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req && rem_wr && (r_kind == K_MSG_TX) && !r_bad
      |=> in_flag[$past(rem_addr[MSEL_W-1:0])]);

  // R4: reserved status bits stay zero
  a_r4_in_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stat & ~IN_VALID) == '0);
  a_r4_out_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stat & ~OUT_VALID) == '0);

  // R5: reserved mask bits stay zero
  a_r5_mask_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_mask & ~IN_VALID) | (out_mask & ~OUT_VALID)) == '0);

  // R6: interrupt needs a status source and a cleared mask
  a_r6_loc_src: assert property (@(posedge clk) disable iff (!rst_n)
    loc_irq |-> (in_stat != '0) && (in_mask != IN_VALID));
  a_r6_rem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mask == OUT_VALID) |-> !rem_irq);

  // R7: without a clear write, inbound doorbell bits never drop
  a_r7_db_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_req && loc_wr && (l_kind == K_DB_RX)) |=> (($past(in_db) & ~in_db) == '0));

  // R9: local side can never raise outbound bits 31:29
  a_r9_db_top: assert property (@(posedge clk) disable iff (!rst_n)
    out_db[31:29] == 3'b000);

  // R11: one response per request, one cycle later
  a_r11_loc_ack: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req |=> loc_ack);
  a_r11_rem_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !rem_req |=> !rem_ack);
endmodule

bind xside_mailbox xside_mailbox_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loc_req   (loc_req),
  .loc_wr    (loc_wr),
  .loc_addr  (loc_addr),
  .loc_ack   (loc_ack),
  .loc_err   (loc_err),
  .loc_rdata (loc_rdata),
  .loc_irq   (loc_irq),
  .rem_req   (rem_req),
  .rem_wr    (rem_wr),
  .rem_addr  (rem_addr),
  .rem_ack   (rem_ack),
  .rem_irq   (rem_irq),
  .in_msg    (in_msg),
  .in_flag   (in_flag),
  .in_db     (in_db),
  .out_db    (out_db),
  .in_stat   (in_stat),
  .out_stat  (out_stat),
  .in_mask   (in_mask),
  .out_mask  (out_mask)
);

// File: tb/xside_mailbox_bench.sv
`timescale 1ns/1ps
module xside_mailbox_bench;
  import xm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_req = 0, loc_wr = 0, rem_req = 0, rem_wr = 0;
  logic [4:0]  loc_addr = '0, rem_addr = '0;
  logic [31:0] loc_wdata = '0, rem_wdata = '0;
  logic        loc_ack, loc_err, loc_irq, rem_ack, rem_err, rem_irq;
  logic [31:0] loc_rdata, rem_rdata;
  logic        mcheck_in = 0, in_post_nempty = 0, out_post_nempty = 0;
  logic        in_post_ovf = 0, out_free_ovf = 0;

  always #4 clk = ~clk;

  xside_mailbox u_xside_mailbox (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] lq_data[$], rq_data[$];
  logic        lq_err[$],  rq_err[$];
  string       lq_tag[$],  rq_tag[$];

  // kind codes: 0 send msg, 1 recv msg, 2 send db, 3 recv db, 4 status, 5 mask
  function automatic logic [4:0] ad(int kind, int idx);
    return {3'(kind), 2'(idx)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lacc(bit w, logic [4:0] a, logic [31:0] d, logic [31:0] exp, bit e, string tag);
    @(negedge clk);
    loc_req = 1; loc_wr = w; loc_addr = a; loc_wdata = d;
    lq_data.push_back(exp); lq_err.push_back(e); lq_tag.push_back(tag);
    @(negedge clk);
    loc_req = 0; loc_wr = 0;
  endtask

  task automatic racc(bit w, logic [4:0] a, logic [31:0] d, logic [31:0] exp, bit e, string tag);
    @(negedge clk);
    rem_req = 1; rem_wr = w; rem_addr = a; rem_wdata = d;
    rq_data.push_back(exp); rq_err.push_back(e); rq_tag.push_back(tag);
    @(negedge clk);
    rem_req = 0; rem_wr = 0;
  endtask

  task automatic both_wr(logic [4:0] la, logic [31:0] ld, logic [4:0] ra, logic [31:0] rd, string tag);
    @(negedge clk);
    loc_req = 1; loc_wr = 1; loc_addr = la; loc_wdata = ld;
    rem_req = 1; rem_wr = 1; rem_addr = ra; rem_wdata = rd;
    lq_data.push_back(0); lq_err.push_back(0); lq_tag.push_back(tag);
    rq_data.push_back(0); rq_err.push_back(0); rq_tag.push_back(tag);
    @(negedge clk);
    loc_req = 0; loc_wr = 0; rem_req = 0; rem_wr = 0;
  endtask

  // bench's own statement of the status layouts (R4)
  function automatic logic [31:0] in_exp(bit m0, bit m1, bit db, bit mc, bit pq, bit po, bit fo);
    return (32'(m0) << 0) | (32'(m1) << 1) | (32'(db) << 3) | (32'(mc) << 4) |
           (32'(pq) << 5) | (32'(po) << 7) | (32'(fo) << 8);
  endfunction
  function automatic logic [31:0] out_exp(bit m0, bit m1, bit db, bit pq);
    return (32'(m0) << 0) | (32'(m1) << 1) | (32'(db) << 3) | (32'(pq) << 5);
  endfunction

  // scoreboard monitors
  always @(negedge clk) begin
    string t;
    if (rst_n && loc_ack) begin
      if (lq_data.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 local: actual ack 1 expected 0");
      end else begin
        t = lq_tag.pop_front();
        chk({t, " data"}, loc_rdata, lq_data.pop_front());
        chk({t, " err"}, 32'(loc_err), 32'(lq_err.pop_front()));
      end
    end
  end

  always @(negedge clk) begin
    string t;
    if (rst_n && rem_ack) begin
      if (rq_data.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 remote: actual ack 1 expected 0");
      end else begin
        t = rq_tag.pop_front();
        chk({t, " data"}, rem_rdata, rq_data.pop_front());
        chk({t, " err"}, 32'(rem_err), 32'(rq_err.pop_front()));
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R6 reset loc_irq", 32'(loc_irq), 0);
    chk("R6 reset rem_irq", 32'(rem_irq), 0);
    chk("R11 reset ack", 32'(loc_ack | rem_ack), 0);
    lacc(0, ad(5,0), 0, 32'h1BB, 0, "R5 inbound mask reset");
    racc(0, ad(5,0), 0, 32'h2B,  0, "R5 outbound mask reset");
    lacc(0, ad(4,0), 0, 0, 0, "R4 inbound status idle");

    // remote posts two messages
    racc(1, ad(0,0), 32'hA5A5_0001, 0, 0, "R11 write response");
    racc(1, ad(0,1), 32'h1234_5678, 0, 0, "R2 post slot 1");
    lacc(0, ad(4,0), 0, in_exp(1,1,0,0,0,0,0), 0, "R2 inbound flags");
    chk("R6 masked msg", 32'(loc_irq), 0);
    lacc(0, ad(1,0), 0, 32'hA5A5_0001, 0, "R3 read slot 0");
    lacc(0, ad(1,0), 0, 32'hA5A5_0001, 0, "R3 reread slot 0");
    lacc(0, ad(1,1), 0, 32'h1234_5678, 0, "R3 read slot 1");
    racc(0, ad(0,0), 0, 32'hA5A5_0001, 0, "R3 sender readback");
    lacc(0, ad(4,0), 0, in_exp(1,1,0,0,0,0,0), 0, "R3 flags untouched by reads");

    // unmask message 0, reserved mask bits dropped
    lacc(1, ad(5,0), 32'hFFFF_FFFE, 0, 0, "R5 mask write");
    lacc(0, ad(5,0), 0, 32'h1BA, 0, "R5 reserved mask bits");
    chk("R6 unmasked msg0", 32'(loc_irq), 1);
    lacc(1, ad(4,0), 32'h1, 0, 0, "R10 clear msg0");
    lacc(0, ad(4,0), 0, in_exp(0,1,0,0,0,0,0), 0, "R10 msg0 cleared");
    chk("R6 after clear", 32'(loc_irq), 0);

    // bad index
    lacc(0, ad(1,2), 0, 0, 1, "R1 local index 2");
    racc(1, ad(0,3), 32'hDEAD_BEEF, 0, 1, "R1 remote index 3");
    lacc(0, ad(1,1), 0, 32'h1234_5678, 0, "R1 slot 1 unchanged");
    lacc(0, ad(4,0), 0, in_exp(0,1,0,0,0,0,0), 0, "R1 flags unchanged");
    lacc(0, ad(6,0), 0, 0, 0, "R1 unused kind reads zero");

    // local posts to remote
    lacc(1, ad(0,1), 32'hCAFE_0002, 0, 0, "R2 local post");
    racc(0, ad(4,0), 0, out_exp(0,1,0,0), 0, "R2 outbound flag");
    racc(0, ad(1,1), 0, 32'hCAFE_0002, 0, "R3 remote receive");

    // inbound doorbell
    racc(1, ad(2,0), 32'h5,  0, 0, "R7 ring a");
    racc(1, ad(2,0), 32'h30, 0, 0, "R7 ring b");
    lacc(0, ad(3,0), 0, 32'h35, 0, "R7 accumulated");
    lacc(0, ad(4,0), 0, in_exp(0,1,1,0,0,0,0), 0, "R4 doorbell bit");
    lacc(1, ad(4,0), 32'h8, 0, 0, "R10 status write db");
    lacc(0, ad(4,0), 0, in_exp(0,1,1,0,0,0,0), 0, "R10 db not clearable");
    lacc(1, ad(3,0), 32'h4, 0, 0, "R8 partial clear");
    lacc(0, ad(3,0), 0, 32'h31, 0, "R8 partial result");
    lacc(0, ad(4,0), 0, in_exp(0,1,1,0,0,0,0), 0, "R8 status held");
    lacc(1, ad(3,0), 32'h31, 0, 0, "R8 full clear");
    lacc(0, ad(4,0), 0, in_exp(0,1,0,0,0,0,0), 0, "R8 status dropped");

    // outbound doorbell from local
    lacc(1, ad(2,0), 32'hFFFF_FFFF, 0, 0, "R9 ring all");
    racc(0, ad(3,0), 0, 32'h1FFF_FFFF, 0, "R9 top bits blocked");
    racc(0, ad(4,0), 0, out_exp(0,1,1,0), 0, "R4 outbound db bit");
    racc(1, ad(5,0), 32'h0, 0, 0, "R5 remote unmask");
    chk("R6 remote irq", 32'(rem_irq), 1);
    racc(1, ad(5,0), 32'hFFFF_FFFF, 0, 0, "R5 remote mask all");
    racc(0, ad(5,0), 0, 32'h2B, 0, "R5 remote reserved");
    chk("R6 remote masked", 32'(rem_irq), 0);
    racc(1, ad(3,0), 32'hFFFF_FFFF, 0, 0, "R8 remote clear");
    racc(0, ad(3,0), 0, 0, 0, "R8 remote cleared");

    // queue and machine-check inputs
    @(negedge clk);
    mcheck_in = 1; in_post_nempty = 1; in_post_ovf = 1; out_free_ovf = 1; out_post_nempty = 1;
    lacc(0, ad(4,0), 0, in_exp(0,1,0,1,1,1,1), 0, "R4 inbound full map");
    racc(0, ad(4,0), 0, out_exp(0,1,0,1), 0, "R4 outbound full map");
    lacc(1, ad(4,0), 32'h1FF, 0, 0, "R10 clear all");
    lacc(0, ad(4,0), 0, in_exp(0,0,0,1,1,1,1), 0, "R10 derived bits kept");
    chk("R6 sources masked", 32'(loc_irq), 0);
    lacc(1, ad(5,0), 32'h1AB, 0, 0, "R6 unmask mcheck");
    chk("R6 mcheck irq", 32'(loc_irq), 1);
    @(negedge clk);
    mcheck_in = 0; in_post_nempty = 0; in_post_ovf = 0; out_free_ovf = 0; out_post_nempty = 0;
    @(negedge clk);
    chk("R6 mcheck gone", 32'(loc_irq), 0);

    // same-cycle post and clear of slot 0
    both_wr(ad(4,0), 32'h1, ad(0,0), 32'h77, "R10 set beats clear");
    lacc(0, ad(4,0), 0, in_exp(1,0,0,0,0,0,0), 0, "R10 flag set");
    lacc(0, ad(1,0), 0, 32'h77, 0, "R3 new slot 0 word");

    repeat (3) @(negedge clk);
    chk("R11 no missing responses", 32'(lq_data.size() + rq_data.size()), 0);
    done = 1;
    finish_run();
  end
endmodule